// File: doc/BRIEF.md
# USB OUT Endpoint Receive Arbiter

This block decides, for the receive side of a USB device, whether an incoming OUT or SETUP data packet goes into the one receive FIFO that all endpoints share, or is refused. Software arms reception with a small register interface. It picks an endpoint number, then sets or clears that endpoint's prime bit, then sets a global receive-enable bit. The prime bits form a persistent bitmap, one bit per endpoint. The enable bit is a one-shot: it drops by itself after every packet that is captured and acknowledged.

The protocol engine supplies a decoded token strobe with its endpoint number and an OUT/SETUP flag. It also supplies data-byte strobes, an end-of-packet strobe and a CRC verdict that is valid with end-of-packet. The block returns a FIFO write port, a FIFO flush strobe and a handshake choice of ACK or NAK. The control endpoint behaves differently from the others. Its prime bit also drops after each capture, so a SETUP packet and the data stage that follows it are taken strictly one at a time, each one re-armed by software.

Top module: `usb_out_rx_arbiter`

## Requirements
- R1: After reset, receive-enable is 0, every prime bit is 0, all four registers read 0 and the outputs fifo_wr, fifo_flush, hs_valid and rx_done are low.
- R2: Register map on cpu_addr:
  - Address 0 is the endpoint select. Bits 3:0 are written and read back, and bits 7:4 read 0.
  - Address 1 reads the selected endpoint's prime bit in bit 0. Bits 7:1 always read 0.
  - Address 2 is the enable bit, in bit 0.
  - Address 3 is read-only. Bits 3:0 hold the endpoint of the last acknowledged capture, and bit 4 is 1 if that packet was a SETUP packet.
- R3: A packet is captured when, in its token cycle, enable is 1 and the addressed endpoint's prime bit is 1. For each rx_dv cycle of a captured packet, fifo_wr is high one cycle later, with fifo_wdata equal to that cycle's rx_data.
- R4: A packet that is not captured produces no fifo_wr. If its end-of-packet carries a good CRC, the block answers NAK one cycle after rx_eop: hs_valid=1 and hs_ack=0.
- R5: A captured packet whose end-of-packet has a good CRC gets an ACK one cycle after rx_eop: hs_valid=1, hs_ack=1 and a one-cycle rx_done. Its endpoint and SETUP flag are latched into address 3.
- R6: An ACKed capture clears enable, so each enable write admits exactly one packet. A second packet sent without a new enable write is NAKed.
- R7: The prime bits of endpoints other than endpoint 0 keep their value across captures.
- R8: The prime bit of endpoint 0, the control endpoint, is cleared by an ACKed capture on endpoint 0.
- R9: If a captured packet ends with a bad CRC, fifo_flush pulses one cycle after rx_eop, and no handshake is issued. Enable and the prime bits are unchanged. A refused packet with a bad CRC gives neither a handshake nor a flush.
- R10: Two CPU writes win over an auto-clear in the same cycle:
  - A write of 1 to enable in the same cycle as an enable auto-clear leaves enable at 1.
  - A write of 1 to endpoint 0's prime bit in the same cycle as its auto-clear leaves that bit at 1.
- R11: rx_dv and rx_eop that arrive outside a packet (with no token since the last end-of-packet) produce no FIFO write, flush or handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_wr | input | 1 | Register write strobe |
| cpu_addr | input | 2 | Register address (0 select, 1 prime, 2 enable, 3 last endpoint) |
| cpu_wdata | input | 8 | Register write data |
| cpu_rdata | output | 8 | Register read data, combinational from cpu_addr |
| tok_valid | input | 1 | One-cycle strobe: an OUT or SETUP token was decoded |
| tok_ep | input | 4 | Endpoint number of the token |
| tok_setup | input | 1 | 1 for a SETUP token, 0 for OUT |
| rx_dv | input | 1 | Data byte valid |
| rx_data | input | 8 | Received data byte |
| rx_eop | input | 1 | End-of-packet strobe |
| rx_crc_ok | input | 1 | CRC verdict, valid with rx_eop |
| fifo_wr | output | 1 | FIFO write strobe |
| fifo_wdata | output | 8 | FIFO write data |
| fifo_flush | output | 1 | Discard the packet just written into the FIFO |
| hs_valid | output | 1 | A handshake is to be sent |
| hs_ack | output | 1 | Handshake kind: 1 ACK, 0 NAK |
| rx_done | output | 1 | One-cycle pulse for a packet that was captured and acknowledged |

## Verification
Each FIFO, handshake and flush output comes from a register, so it is due exactly one clock edge after the rx_dv or rx_eop cycle that causes it. The register readback is combinational, so the new enable and prime state can already be read on the cycle after that same edge. The bench drives every stimulus on a falling edge and samples the matching result on the next falling edge. Where a result must not appear, it also samples one cycle later. The bench tracks enable, prime bits and last endpoint in its own model and computes every expected value from that model. It sweeps all 16 endpoints across all four prime/enable combinations, and it forces the CPU-versus-auto-clear collisions on the exact end-of-packet cycle.

// File: rtl/usb_rx_pkg.sv
package usb_rx_pkg;

  typedef enum logic [1:0] {
    REG_SEL    = 2'd0,
    REG_PRIME  = 2'd1,
    REG_ENABLE = 2'd2,
    REG_LAST   = 2'd3
  } reg_addr_e;

  typedef enum logic [1:0] {
    RX_IDLE = 2'd0,
    RX_TAKE = 2'd1,
    RX_DROP = 2'd2
  } rx_state_e;

  // Capture decision taken in the token cycle.
  function automatic logic ep_armed(input logic enable, input logic prime_bit);
    return enable & prime_bit;
  endfunction

endpackage

// File: rtl/usb_rx_regs.sv
module usb_rx_regs
  import usb_rx_pkg::*;
#(
  parameter int unsigned EP_W   = 4,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_wr,
  input  logic [1:0]        cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  input  logic              prime_bit_sel,
  input  logic [EP_W-1:0]   last_ep,
  input  logic              last_setup,
  input  logic              clr_en_evt,
  output logic [EP_W-1:0]   sel_ep,
  output logic              enable,
  output logic              prime_wr,
  output logic              prime_wval,
  output logic              en_wr
);

  reg_addr_e        addr;
  logic             sel_wr;
  logic [EP_W-1:0]  sel_q;
  logic             enable_q;
  logic             unused_wdata;

  assign addr         = reg_addr_e'(cpu_addr);
  assign sel_wr       = cpu_wr && (addr == REG_SEL);
  assign prime_wr     = cpu_wr && (addr == REG_PRIME);
  assign en_wr        = cpu_wr && (addr == REG_ENABLE);
  assign prime_wval   = cpu_wdata[0];
  assign unused_wdata = ^cpu_wdata;

  function automatic logic [DATA_W-1:0] last_word(input logic [EP_W-1:0] ep,
                                                   input logic setup);
    logic [DATA_W-1:0] w;
    w = '0;
    w[EP_W-1:0] = ep;
    w[EP_W]     = setup;
    return w;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
    end else if (sel_wr) begin
      sel_q <= cpu_wdata[EP_W-1:0];
    end
  end

  // A CPU write takes priority over the auto-clear.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enable_q <= 1'b0;
    end else if (en_wr) begin
      enable_q <= cpu_wdata[0];
    end else if (clr_en_evt) begin
      enable_q <= 1'b0;
    end
  end

  always_comb begin
    cpu_rdata = '0;
    case (addr)
      REG_SEL:    cpu_rdata[EP_W-1:0] = sel_q;
      REG_PRIME:  cpu_rdata[0] = prime_bit_sel;
      REG_ENABLE: cpu_rdata[0] = enable_q;
      REG_LAST:   cpu_rdata = last_word(last_ep, last_setup);
      default:    cpu_rdata = '0;
    endcase
  end

  assign sel_ep = sel_q;
  assign enable = enable_q;

  // R6
  en_autoclr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en_evt && !en_wr |=> !enable_q);

  // R10
  en_cpu_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_wr && cpu_wdata[0] |=> enable_q);

endmodule

// File: rtl/usb_rx_prime_map.sv
module usb_rx_prime_map #(
  parameter int unsigned NUM_EP  = 16,
  parameter int unsigned EP_W    = 4,
  parameter int unsigned CTRL_EP = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prime_wr,
  input  logic              prime_wval,
  input  logic [EP_W-1:0]   sel_ep,
  input  logic              clr_ctrl_evt,
  output logic [NUM_EP-1:0] prime_vec
);

  localparam logic [NUM_EP-1:0] CTRL_MASK = NUM_EP'(1) << CTRL_EP;

  logic ctrl_hit;
  assign ctrl_hit = prime_wr && (sel_ep == EP_W'(CTRL_EP));

  for (genvar e = 0; e < NUM_EP; e++) begin : g_ep
    logic hit;
    logic bit_q;
    assign hit = prime_wr && (sel_ep == EP_W'(e));

    if (e == CTRL_EP) begin : g_ctrl
      // Control endpoint: one capture per prime; a CPU write wins.
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          bit_q <= 1'b0;
        end else if (hit) begin
          bit_q <= prime_wval;
        end else if (clr_ctrl_evt) begin
          bit_q <= 1'b0;
        end
      end
    end else begin : g_data
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          bit_q <= 1'b0;
        end else if (hit) begin
          bit_q <= prime_wval;
        end
      end
    end

    assign prime_vec[e] = bit_q;
  end

  // R8
  ctrl_autoclr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_ctrl_evt && !ctrl_hit |=> !prime_vec[CTRL_EP]);

  // R10
  ctrl_cpu_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_hit && prime_wval |=> prime_vec[CTRL_EP]);

  // R7
  data_prime_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !prime_wr |=> ((prime_vec ^ $past(prime_vec)) & ~CTRL_MASK) == '0);

endmodule

// File: rtl/usb_rx_pkt_ctrl.sv
module usb_rx_pkt_ctrl
  import usb_rx_pkg::*;
#(
  parameter int unsigned NUM_EP  = 16,
  parameter int unsigned EP_W    = 4,
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned CTRL_EP = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tok_valid,
  input  logic [EP_W-1:0]   tok_ep,
  input  logic              tok_setup,
  input  logic              rx_dv,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              rx_eop,
  input  logic              rx_crc_ok,
  input  logic              enable,
  input  logic [NUM_EP-1:0] prime_vec,
  output logic              fifo_wr,
  output logic [DATA_W-1:0] fifo_wdata,
  output logic              fifo_flush,
  output logic              hs_valid,
  output logic              hs_ack,
  output logic              rx_done,
  output logic [EP_W-1:0]   last_ep,
  output logic              last_setup,
  output logic              clr_en_evt,
  output logic              clr_ctrl_evt
);

  rx_state_e        state_q, state_d;
  logic [EP_W-1:0]  cur_ep_q;
  logic             cur_setup_q;
  logic             arm_now;
  logic             take_end, drop_end;
  logic             good_take, bad_take, drop_nak;

  // Named events for the checks.
  assign arm_now   = ep_armed(enable, prime_vec[tok_ep]);
  assign take_end  = (state_q == RX_TAKE) && rx_eop;
  assign drop_end  = (state_q == RX_DROP) && rx_eop;
  assign good_take = take_end && rx_crc_ok;
  assign bad_take  = take_end && !rx_crc_ok;
  assign drop_nak  = drop_end && rx_crc_ok;

  assign clr_en_evt   = good_take;
  assign clr_ctrl_evt = good_take && (cur_ep_q == EP_W'(CTRL_EP));

  always_comb begin
    state_d = state_q;
    if (tok_valid) begin
      state_d = arm_now ? RX_TAKE : RX_DROP;
    end else if (rx_eop) begin
      state_d = RX_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= RX_IDLE;
      cur_ep_q    <= '0;
      cur_setup_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (tok_valid) begin
        cur_ep_q    <= tok_ep;
        cur_setup_q <= tok_setup;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fifo_wr    <= 1'b0;
      fifo_wdata <= '0;
      fifo_flush <= 1'b0;
      hs_valid   <= 1'b0;
      hs_ack     <= 1'b0;
      rx_done    <= 1'b0;
      last_ep    <= '0;
      last_setup <= 1'b0;
    end else begin
      fifo_wr    <= (state_q == RX_TAKE) && rx_dv;
      if (rx_dv) begin
        fifo_wdata <= rx_data;
      end
      fifo_flush <= bad_take;
      hs_valid   <= good_take || drop_nak;
      hs_ack     <= good_take;
      rx_done    <= good_take;
      if (good_take) begin
        last_ep    <= cur_ep_q;
        last_setup <= cur_setup_q;
      end
    end
  end

  // R3
  take_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == RX_TAKE) && rx_dv |=> fifo_wr && (fifo_wdata == $past(rx_data)));

  // R4
  refuse_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != RX_TAKE) |=> !fifo_wr);

  // R5
  done_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |-> hs_valid && hs_ack);

  // R9
  flush_nohs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_flush |-> !hs_valid && !rx_done);

  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == RX_IDLE) |=> !fifo_wr && !hs_valid && !fifo_flush);

endmodule

// File: rtl/usb_out_rx_arbiter.sv
module usb_out_rx_arbiter #(
  parameter int unsigned NUM_EP  = 16,
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned CTRL_EP = 0,
  localparam int unsigned EP_W   = $clog2(NUM_EP)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_wr,
  input  logic [1:0]        cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  input  logic              tok_valid,
  input  logic [EP_W-1:0]   tok_ep,
  input  logic              tok_setup,
  input  logic              rx_dv,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              rx_eop,
  input  logic              rx_crc_ok,
  output logic              fifo_wr,
  output logic [DATA_W-1:0] fifo_wdata,
  output logic              fifo_flush,
  output logic              hs_valid,
  output logic              hs_ack,
  output logic              rx_done
);

  logic [EP_W-1:0]   sel_ep;
  logic              enable;
  logic              prime_wr, prime_wval, en_wr;
  logic [NUM_EP-1:0] prime_vec;
  logic [EP_W-1:0]   last_ep;
  logic              last_setup;
  logic              clr_en_evt, clr_ctrl_evt;

  usb_rx_regs #(
    .EP_W   (EP_W),
    .DATA_W (DATA_W)
  ) u_regs (
    .clk           (clk),
    .rst_n         (rst_n),
    .cpu_wr        (cpu_wr),
    .cpu_addr      (cpu_addr),
    .cpu_wdata     (cpu_wdata),
    .cpu_rdata     (cpu_rdata),
    .prime_bit_sel (prime_vec[sel_ep]),
    .last_ep       (last_ep),
    .last_setup    (last_setup),
    .clr_en_evt    (clr_en_evt),
    .sel_ep        (sel_ep),
    .enable        (enable),
    .prime_wr      (prime_wr),
    .prime_wval    (prime_wval),
    .en_wr         (en_wr)
  );

  usb_rx_prime_map #(
    .NUM_EP  (NUM_EP),
    .EP_W    (EP_W),
    .CTRL_EP (CTRL_EP)
  ) u_prime (
    .clk          (clk),
    .rst_n        (rst_n),
    .prime_wr     (prime_wr),
    .prime_wval   (prime_wval),
    .sel_ep       (sel_ep),
    .clr_ctrl_evt (clr_ctrl_evt),
    .prime_vec    (prime_vec)
  );

  usb_rx_pkt_ctrl #(
    .NUM_EP  (NUM_EP),
    .EP_W    (EP_W),
    .DATA_W  (DATA_W),
    .CTRL_EP (CTRL_EP)
  ) u_pkt (
    .clk          (clk),
    .rst_n        (rst_n),
    .tok_valid    (tok_valid),
    .tok_ep       (tok_ep),
    .tok_setup    (tok_setup),
    .rx_dv        (rx_dv),
    .rx_data      (rx_data),
    .rx_eop       (rx_eop),
    .rx_crc_ok    (rx_crc_ok),
    .enable       (enable),
    .prime_vec    (prime_vec),
    .fifo_wr      (fifo_wr),
    .fifo_wdata   (fifo_wdata),
    .fifo_flush   (fifo_flush),
    .hs_valid     (hs_valid),
    .hs_ack       (hs_ack),
    .rx_done      (rx_done),
    .last_ep      (last_ep),
    .last_setup   (last_setup),
    .clr_en_evt   (clr_en_evt),
    .clr_ctrl_evt (clr_ctrl_evt)
  );

  // R9
  flush_keeps_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_flush && !$past(en_wr) |-> $stable(enable));

  // R1
  reset_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !enable && (prime_vec == '0));

endmodule

// File: tb/test_usb_out_rx_arbiter.sv
`timescale 1ns/1ps
module test_usb_out_rx_arbiter;

  localparam int CLK_NS = 8;
  localparam int NEP = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cpu_wr = 1'b0;
  logic [1:0] cpu_addr = '0;
  logic [7:0] cpu_wdata = '0;
  logic [7:0] cpu_rdata;
  logic tok_valid = 1'b0;
  logic [3:0] tok_ep = '0;
  logic tok_setup = 1'b0;
  logic rx_dv = 1'b0;
  logic [7:0] rx_data = '0;
  logic rx_eop = 1'b0;
  logic rx_crc_ok = 1'b0;
  logic fifo_wr, fifo_flush, hs_valid, hs_ack, rx_done;
  logic [7:0] fifo_wdata;

  int n_checks = 0;
  int n_err = 0;
  bit finished = 0;

  // bench model
  logic [NEP-1:0] m_prime = '0;
  logic m_en = 1'b0;
  int m_sel = 0;
  logic [3:0] m_last = '0;
  logic m_last_setup = 1'b0;

  always #(CLK_NS/2) clk = ~clk;

  usb_out_rx_arbiter i_usb_out_rx_arbiter (
    .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .tok_valid(tok_valid),
    .tok_ep(tok_ep), .tok_setup(tok_setup), .rx_dv(rx_dv), .rx_data(rx_data),
    .rx_eop(rx_eop), .rx_crc_ok(rx_crc_ok), .fifo_wr(fifo_wr),
    .fifo_wdata(fifo_wdata), .fifo_flush(fifo_flush), .hs_valid(hs_valid),
    .hs_ack(hs_ack), .rx_done(rx_done)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic cpu_write(input logic [1:0] a, input logic [7:0] d);
    cpu_wr = 1'b1; cpu_addr = a; cpu_wdata = d;
    tick();
    cpu_wr = 1'b0;
  endtask

  task automatic cpu_read(input logic [1:0] a, output logic [7:0] v);
    cpu_addr = a;
    #1;
    v = cpu_rdata;
  endtask

  function automatic logic [7:0] byte_of(input int ep, input int i);
    return 8'((ep * 16) + (i * 3) + 1);
  endfunction

  task automatic select_ep(input int ep);
    cpu_write(2'd0, 8'(ep));
    m_sel = ep;
  endtask

  task automatic set_prime(input logic v);
    cpu_write(2'd1, {7'd0, v});
    m_prime[m_sel] = v;
  endtask

  task automatic set_enable(input logic v);
    cpu_write(2'd2, {7'd0, v});
    m_en = v;
  endtask

  // coll: 0 none, 1 write enable=1 on the eop cycle, 2 write prime=1 on the eop cycle
  task automatic send_packet(input int ep, input logic setup, input int nbytes,
                             input logic crc_ok, input int coll);
    logic arm, ok;
    logic [7:0] v;
    arm = m_en && m_prime[ep];
    tok_valid = 1'b1; tok_ep = 4'(ep); tok_setup = setup;
    tick();
    tok_valid = 1'b0;
    for (int i = 0; i < nbytes; i++) begin
      rx_dv = 1'b1; rx_data = byte_of(ep, i);
      tick();
      rx_dv = 1'b0;
      if (arm) begin
        check("R3", "fifo_wr on captured byte", fifo_wr, 1);
        check("R3", "fifo_wdata", fifo_wdata, byte_of(ep, i));
      end else begin
        check("R4", "fifo_wr on refused byte", fifo_wr, 0);
      end
    end
    rx_eop = 1'b1; rx_crc_ok = crc_ok;
    if (coll == 1) begin cpu_wr = 1'b1; cpu_addr = 2'd2; cpu_wdata = 8'd1; end
    if (coll == 2) begin cpu_wr = 1'b1; cpu_addr = 2'd1; cpu_wdata = 8'd1; end
    tick();
    rx_eop = 1'b0; rx_crc_ok = 1'b0; cpu_wr = 1'b0;
    ok = crc_ok && arm;
    if (ok) begin
      m_en = 1'b0;
      if (ep == 0) m_prime[0] = 1'b0;
      m_last = 4'(ep);
      m_last_setup = setup;
    end
    if (coll == 1) m_en = 1'b1;
    if (coll == 2) m_prime[m_sel] = 1'b1;
    check(arm ? "R5" : "R4", "hs_valid", hs_valid, crc_ok);
    check(arm ? "R5" : "R4", "hs_ack", hs_ack, ok);
    check("R5", "rx_done", rx_done, ok);
    check("R9", "fifo_flush", fifo_flush, !crc_ok && arm);
    cpu_read(2'd2, v);
    check(coll == 1 ? "R10" : "R6", "enable after packet", v, {7'd0, m_en});
    cpu_read(2'd1, v);
    check(ep == 0 ? "R8" : "R7", "selected prime after packet", v, {7'd0, m_prime[m_sel]});
    cpu_read(2'd3, v);
    check("R5", "last endpoint register", v, {3'd0, m_last_setup, m_last});
    tick();
    check("R5", "pulses one cycle wide", {hs_valid, rx_done, fifo_flush}, 0);
  endtask

  initial begin
    #(CLK_NS * 150000);
    if (!finished) begin
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();

    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      cpu_read(2'(a), v);
      check("R1", "register after reset", v, 0);
    end
    check("R1", "outputs after reset", {fifo_wr, fifo_flush, hs_valid, rx_done}, 0);
    for (int e = 0; e < NEP; e++) begin
      select_ep(e);
      cpu_read(2'd1, v);
      check("R1", "prime after reset", v, 0);
    end

    // R2 field positions
    cpu_write(2'd0, 8'hF5); m_sel = 5;
    cpu_read(2'd0, v);
    check("R2", "select readback low nibble", v, 8'h05);
    cpu_write(2'd1, 8'hFF); m_prime[5] = 1'b1;
    cpu_read(2'd1, v);
    check("R2", "prime reads bit 0 only", v, 8'h01);
    set_prime(1'b0);
    cpu_write(2'd2, 8'hFE); m_en = 1'b0;
    cpu_read(2'd2, v);
    check("R2", "enable takes bit 0", v, 8'h00);

    // R11 stray data and eop
    rx_dv = 1'b1; rx_data = 8'hA5; rx_eop = 1'b1; rx_crc_ok = 1'b1;
    tick();
    rx_dv = 1'b0; rx_eop = 1'b0; rx_crc_ok = 1'b0;
    check("R11", "no activity outside packet",
          {fifo_wr, fifo_flush, hs_valid, rx_done}, 0);

    // Sweep: every endpoint, every prime/enable combination (R3..R8)
    for (int e = 0; e < NEP; e++) begin
      for (int p = 0; p < 4; p++) begin
        select_ep(e);
        set_prime(p[0]);
        set_enable(p[1]);
        send_packet(e, e[0], 1 + (e % 3), 1'b1, 0);
      end
    end
    // R7 / R8: all primes after sweep
    for (int e = 0; e < NEP; e++) begin
      select_ep(e);
      cpu_read(2'd1, v);
      check(e == 0 ? "R8" : "R7", "prime after sweep", v, {7'd0, m_prime[e]});
    end

    // R6 one packet per enable
    select_ep(3); set_prime(1'b1); set_enable(1'b1);
    send_packet(3, 1'b0, 2, 1'b1, 0);
    send_packet(3, 1'b0, 2, 1'b1, 0);
    check("R6", "second packet not captured (model enable)", m_en, 0);

    // R4 wrong endpoint
    select_ep(4); set_prime(1'b0); set_enable(1'b1);
    send_packet(4, 1'b0, 1, 1'b1, 0);
    check("R4", "enable kept after NAK", m_en, 1);

    // R9 bad CRC on a captured packet, then a good one
    select_ep(3);
    send_packet(3, 1'b1, 3, 1'b0, 0);
    send_packet(3, 1'b1, 1, 1'b1, 0);
    // R9 bad CRC on a refused packet
    send_packet(3, 1'b0, 1, 1'b0, 0);

    // R10 enable collision
    set_enable(1'b1);
    send_packet(3, 1'b0, 1, 1'b1, 1);
    send_packet(3, 1'b0, 1, 1'b1, 0);

    // R10 control prime collision
    select_ep(0); set_prime(1'b1); set_enable(1'b1);
    send_packet(0, 1'b1, 2, 1'b1, 2);
    set_enable(1'b1);
    send_packet(0, 1'b0, 1, 1'b1, 0);
    send_packet(0, 1'b0, 1, 1'b1, 0);

    finished = 1;
    $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

endmodule